// File: doc/BRIEF.md
# Paged Switch Register Access Bridge

This block lets a host processor reach a paged internal register space through a small window of 32-bit memory-mapped registers. Each target is named by an 8-bit page and an 8-bit register offset, and each transfer moves up to 64 bits of data. Before it issues a command, the host must win ownership of the back-end port through a request/grant handshake. The host then loads the two write-data words and writes a command word that carries the page, the register, the direction and a go bit. The go bit reads back as busy until the transfer finishes.

On the back end, the bridge drives a one-cycle strobe carrying the page, register, write enable and 64-bit write data. It then waits for a response, which arrives 1 to 8 cycles later. A separate capture register collects event pulses from the switch. The captured events, gated by an enable bit, drive a single host interrupt line.

Top module: `paged_reg_bridge`

## Requirements
- R1: After synchronous reset, every window register reads zero, except the switch-ready bit in the control word. Grant, interrupt and the back-end strobe are all low.
- R2: Control word at offset 0x40. Bit 1 is the interrupt enable, bit 3 the host request, bit 4 the grant, and bit 6 mirrors the `sw_ready` input. Grant rises one cycle after the request bit is set, provided `fabric_own` is low. It stays high while the request is held and falls one cycle after the request is cleared.
- R3: Command word at offset 0x2C. Bits 31:24 hold the page, bits 23:16 the register, bit 2 is abort, bit 1 selects write (1) or read (0), and bit 0 is go. Bit 0 reads 1 from the cycle a command is accepted until the transfer completes.
- R4: A command written while grant is low, or while a transfer is busy, changes nothing. The command word readback keeps its previous value.
- R5: Write data is split into a high word at offset 0x30 and a low word at offset 0x34. Both words can be read back, and the back end receives them as {high, low}.
- R6: In the cycle after a command is accepted, `be_valid` is high for exactly one cycle. During that cycle, `be_page`, `be_reg`, `be_we` and `be_wdata` carry the accepted command.
- R7: The response to a read is stored on the same edge that clears busy. Its upper half goes to the high read word at 0x38 and its lower half to the low read word at 0x3C. The response to a write leaves both read words unchanged.
- R8: A command write with bit 2 set cancels any transfer in progress and zeroes both read words on the next edge. A response that arrives afterwards is ignored.
- R9: The capture register at offset 0x44 holds 13 event bits, which set on input pulses. Writing a 1 to a bit clears it, but a pulse arriving in the same cycle keeps the bit set.
- R10: `irq` is high exactly when the interrupt enable is set and at least one captured bit is set.
- R11: Read data is presented one cycle after `bus_rd`. Offsets not listed above read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Host byte offset |
| bus_wr | input | 1 | Host write strobe |
| bus_wdata | input | 32 | Host write data |
| bus_rd | input | 1 | Host read strobe |
| bus_rdata | output | 32 | Host read data, one cycle after bus_rd |
| sw_ready | input | 1 | Switch initialisation complete |
| fabric_own | input | 1 | An internal agent currently holds the back-end port |
| evt_pulse | input | 13 | Event pulses to capture |
| irq | output | 1 | Host interrupt |
| be_valid | output | 1 | Back-end command strobe |
| be_page | output | 8 | Back-end page |
| be_reg | output | 8 | Back-end register |
| be_we | output | 1 | Back-end write enable |
| be_wdata | output | 64 | Back-end write data |
| be_rsp_valid | input | 1 | Back-end response strobe |
| be_rsp_data | input | 64 | Back-end response data |

## Verification
Reads and writes are run against responses with latencies of 1, 3, 6 and 8 cycles. This separates correct completion tracking from logic that assumes a fixed response delay. Commands are also issued without grant, while busy, and together with an abort, each against a pending response. This checks that refused or cancelled commands leave the command readback and the read words unchanged. Event pulses are applied alone, together with a clear of the same bit, and with the interrupt enable both on and off. This separates a correct write-1-to-clear priority from one that lets the clear win.

// File: rtl/prb_pkg.sv
package prb_pkg;
  localparam logic [7:0] OFS_CMD  = 8'h2C;
  localparam logic [7:0] OFS_WDH  = 8'h30;
  localparam logic [7:0] OFS_WDL  = 8'h34;
  localparam logic [7:0] OFS_RDH  = 8'h38;
  localparam logic [7:0] OFS_RDL  = 8'h3C;
  localparam logic [7:0] OFS_CTRL = 8'h40;
  localparam logic [7:0] OFS_EVT  = 8'h44;

  localparam int CMD_GO    = 0;
  localparam int CMD_WR    = 1;
  localparam int CMD_ABORT = 2;
  localparam int CTL_IEN   = 1;
  localparam int CTL_REQ   = 3;
  localparam int CTL_GNT   = 4;
  localparam int CTL_RDY   = 6;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ISSUE = 2'd1,
    SEQ_WAIT  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/prb_own.sv
module prb_own (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic fabric_own_i,
  output logic gnt_o
);
  logic gnt_q;

  always_ff @(posedge clk) begin
    if (rst) gnt_q <= 1'b0;
    else     gnt_q <= req_i && (gnt_q || !fabric_own_i);
  end

  assign gnt_o = gnt_q;

  AST_GNT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> !gnt_q); // R2
  AST_GNT_AWARD: assert property (@(posedge clk) disable iff (rst)
    (req_i && !fabric_own_i) |=> gnt_q); // R2
  AST_GNT_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (!gnt_q && fabric_own_i) |=> !gnt_q); // R2
endmodule

// File: rtl/prb_evt.sv
module prb_evt #(
  parameter int NEVT = 13
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NEVT-1:0] pulse_i,
  input  logic            clr_we_i,
  input  logic [NEVT-1:0] clr_mask_i,
  output logic [NEVT-1:0] cap_o
);
  logic [NEVT-1:0] cap_q;
  logic [NEVT-1:0] clr;

  assign clr = clr_we_i ? clr_mask_i : '0;

  for (genvar i = 0; i < NEVT; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) cap_q[i] <= 1'b0;
      else     cap_q[i] <= (cap_q[i] && !clr[i]) || pulse_i[i];
    end
  end

  assign cap_o = cap_q;

  AST_EVT_LATCH: assert property (@(posedge clk) disable iff (rst)
    (|pulse_i) |=> ((cap_q & $past(pulse_i)) == $past(pulse_i))); // R9
  AST_EVT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!clr_we_i && pulse_i == '0) |=> $stable(cap_q)); // R9
endmodule

// File: rtl/prb_seq.sv
module prb_seq
  import prb_pkg::*;
#(
  parameter int PG_W = 8,
  parameter int RG_W = 8,
  parameter int BW   = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go_i,
  input  logic            abort_i,
  input  logic            grant_i,
  input  logic [PG_W-1:0] page_i,
  input  logic [RG_W-1:0] reg_i,
  input  logic            wr_i,
  input  logic [BW-1:0]   wdata_i,
  input  logic            rsp_valid_i,
  input  logic [BW-1:0]   rsp_data_i,
  output logic            busy_o,
  output logic [PG_W-1:0] page_o,
  output logic [RG_W-1:0] reg_o,
  output logic            wr_o,
  output logic [BW-1:0]   rd_data_o,
  output logic            be_valid_o,
  output logic [BW-1:0]   be_wdata_o
);
  seq_state_e      st_q;
  logic [PG_W-1:0] page_q;
  logic [RG_W-1:0] reg_q;
  logic            wr_q;
  logic [BW-1:0]   wdat_q;
  logic [BW-1:0]   rd_q;
  logic            accept;

  assign accept = go_i && grant_i && (st_q == SEQ_IDLE) && !abort_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SEQ_IDLE;
      page_q <= '0;
      reg_q  <= '0;
      wr_q   <= 1'b0;
      wdat_q <= '0;
      rd_q   <= '0;
    end else if (abort_i) begin
      st_q <= SEQ_IDLE;
      rd_q <= '0;
    end else if (accept) begin
      st_q   <= SEQ_ISSUE;
      page_q <= page_i;
      reg_q  <= reg_i;
      wr_q   <= wr_i;
      wdat_q <= wdata_i;
    end else begin
      case (st_q)
        SEQ_ISSUE: st_q <= SEQ_WAIT;
        SEQ_WAIT: if (rsp_valid_i) begin
          st_q <= SEQ_IDLE;
          if (!wr_q) rd_q <= rsp_data_i;
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q != SEQ_IDLE);
  assign be_valid_o = (st_q == SEQ_ISSUE);
  assign page_o     = page_q;
  assign reg_o      = reg_q;
  assign wr_o       = wr_q;
  assign rd_data_o  = rd_q;
  assign be_wdata_o = wdat_q;

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    be_valid_o |=> !be_valid_o); // R6
  AST_NO_GRANT_DROP: assert property (@(posedge clk) disable iff (rst)
    (go_i && !grant_i && !abort_i && !busy_o) |=> !busy_o); // R4
  AST_BUSY_KEEPS_CMD: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !abort_i) |=> $stable(page_q) && $stable(reg_q)); // R4
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> (!busy_o && rd_q == '0)); // R8
  AST_RSP_DONE: assert property (@(posedge clk) disable iff (rst)
    (st_q == SEQ_WAIT && rsp_valid_i && !abort_i) |=> !busy_o); // R7
endmodule

// File: rtl/paged_reg_bridge.sv
module paged_reg_bridge
  import prb_pkg::*;
#(
  parameter int AW   = 8,
  parameter int DW   = 32,
  parameter int PG_W = 8,
  parameter int RG_W = 8,
  parameter int NEVT = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_rd,
  output logic [DW-1:0]     bus_rdata,
  input  logic              sw_ready,
  input  logic              fabric_own,
  input  logic [NEVT-1:0]   evt_pulse,
  output logic              irq,
  output logic              be_valid,
  output logic [PG_W-1:0]   be_page,
  output logic [RG_W-1:0]   be_reg,
  output logic              be_we,
  output logic [2*DW-1:0]   be_wdata,
  input  logic              be_rsp_valid,
  input  logic [2*DW-1:0]   be_rsp_data
);
  localparam int BW     = 2 * DW;
  localparam int PG_LSB = DW - PG_W;
  localparam int RG_LSB = PG_LSB - RG_W;
  localparam int CMD_PAD = RG_LSB - 2;

  logic [DW-1:0]   wdh_q, wdl_q, rdata_q;
  logic            req_q, ien_q, gnt;
  logic            wr_cmd, go, abort, busy, cmd_wr;
  logic [PG_W-1:0] cmd_page;
  logic [RG_W-1:0] cmd_reg;
  logic [BW-1:0]   rd_data;
  logic [NEVT-1:0] cap;
  logic [DW-1:0]   rmux;

  assign wr_cmd = bus_wr && (bus_addr == AW'(OFS_CMD));
  assign abort  = wr_cmd && bus_wdata[CMD_ABORT];
  assign go     = wr_cmd && bus_wdata[CMD_GO] && !bus_wdata[CMD_ABORT];

  always_ff @(posedge clk) begin
    if (rst) begin
      wdh_q <= '0;
      wdl_q <= '0;
      req_q <= 1'b0;
      ien_q <= 1'b0;
    end else if (bus_wr) begin
      if (bus_addr == AW'(OFS_WDH)) wdh_q <= bus_wdata;
      if (bus_addr == AW'(OFS_WDL)) wdl_q <= bus_wdata;
      if (bus_addr == AW'(OFS_CTRL)) begin
        req_q <= bus_wdata[CTL_REQ];
        ien_q <= bus_wdata[CTL_IEN];
      end
    end
  end

  prb_own u_own (
    .clk          (clk),
    .rst          (rst),
    .req_i        (req_q),
    .fabric_own_i (fabric_own),
    .gnt_o        (gnt)
  );

  prb_seq #(.PG_W(PG_W), .RG_W(RG_W), .BW(BW)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .go_i        (go),
    .abort_i     (abort),
    .grant_i     (gnt),
    .page_i      (bus_wdata[DW-1:PG_LSB]),
    .reg_i       (bus_wdata[PG_LSB-1:RG_LSB]),
    .wr_i        (bus_wdata[CMD_WR]),
    .wdata_i     ({wdh_q, wdl_q}),
    .rsp_valid_i (be_rsp_valid),
    .rsp_data_i  (be_rsp_data),
    .busy_o      (busy),
    .page_o      (cmd_page),
    .reg_o       (cmd_reg),
    .wr_o        (cmd_wr),
    .rd_data_o   (rd_data),
    .be_valid_o  (be_valid),
    .be_wdata_o  (be_wdata)
  );

  prb_evt #(.NEVT(NEVT)) u_evt (
    .clk        (clk),
    .rst        (rst),
    .pulse_i    (evt_pulse),
    .clr_we_i   (bus_wr && (bus_addr == AW'(OFS_EVT))),
    .clr_mask_i (bus_wdata[NEVT-1:0]),
    .cap_o      (cap)
  );

  always_comb begin
    rmux = '0;
    case (bus_addr)
      AW'(OFS_CMD):  rmux = {cmd_page, cmd_reg, {CMD_PAD{1'b0}}, cmd_wr, busy};
      AW'(OFS_WDH):  rmux = wdh_q;
      AW'(OFS_WDL):  rmux = wdl_q;
      AW'(OFS_RDH):  rmux = rd_data[BW-1:DW];
      AW'(OFS_RDL):  rmux = rd_data[DW-1:0];
      AW'(OFS_CTRL): begin
        rmux[CTL_RDY] = sw_ready;
        rmux[CTL_GNT] = gnt;
        rmux[CTL_REQ] = req_q;
        rmux[CTL_IEN] = ien_q;
      end
      AW'(OFS_EVT):  rmux = DW'(cap);
      default:       rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rmux;
  end

  assign bus_rdata = rdata_q;
  assign irq       = ien_q && (|cap);
  assign be_page   = cmd_page;
  assign be_reg    = cmd_reg;
  assign be_we     = cmd_wr;

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !ien_q |-> !irq); // R10
  AST_STROBE_OWNED: assert property (@(posedge clk) disable iff (rst)
    be_valid |-> $past(gnt)); // R6
endmodule

// File: tb/test_paged_reg_bridge.sv
module test_paged_reg_bridge;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sw_ready = 1'b1, fabric_own = 1'b0;
  logic [12:0] evt_pulse = '0;
  logic        irq, be_valid, be_we;
  logic [7:0]  be_page, be_reg;
  logic [63:0] be_wdata;
  logic        be_rsp_valid = 1'b0;
  logic [63:0] be_rsp_data = '0;

  int checks = 0, fails = 0, cyc = 0;
  int rsp_lat = 1, rsp_cnt = 0;
  bit rsp_pend = 0;
  logic [7:0] rsp_pg, rsp_rg;

  // reference model state
  bit          m_req, m_gnt, m_ien, m_busy, m_issue, m_wr;
  logic [7:0]  m_page, m_reg;
  logic [31:0] m_wdh, m_wdl, m_rdata;
  logic [63:0] m_rd, m_bwd;
  logic [12:0] m_evt;

  always #(CLK_PERIOD/2) clk = ~clk;

  paged_reg_bridge i_paged_reg_bridge (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .sw_ready(sw_ready), .fabric_own(fabric_own),
    .evt_pulse(evt_pulse), .irq(irq), .be_valid(be_valid), .be_page(be_page),
    .be_reg(be_reg), .be_we(be_we), .be_wdata(be_wdata),
    .be_rsp_valid(be_rsp_valid), .be_rsp_data(be_rsp_data)
  );

  function automatic logic [63:0] rsp_pattern(logic [7:0] pg, logic [7:0] rg);
    return 64'h0123_4567_89AB_CDEF ^ {pg, rg, 48'h0} ^ {48'h0, rg, pg};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_req = 0; m_gnt = 0; m_ien = 0; m_busy = 0; m_issue = 0; m_wr = 0;
      m_page = 0; m_reg = 0; m_wdh = 0; m_wdl = 0; m_rdata = 0; m_rd = 0; m_bwd = 0; m_evt = 0;
    end else begin
      logic [31:0] rv;
      bit n_gnt;
      rv = 0;
      case (bus_addr)
        8'h2C: rv = {m_page, m_reg, 14'h0, m_wr, m_busy};
        8'h30: rv = m_wdh;
        8'h34: rv = m_wdl;
        8'h38: rv = m_rd[63:32];
        8'h3C: rv = m_rd[31:0];
        8'h40: rv = {25'h0, sw_ready, 1'b0, m_gnt, m_req, 1'b0, m_ien, 1'b0};
        8'h44: rv = {19'h0, m_evt};
        default: rv = 0;
      endcase
      if (bus_rd) m_rdata = rv;
      n_gnt = m_req && (m_gnt || !fabric_own);
      if (bus_wr && bus_addr == 8'h2C && bus_wdata[2]) begin
        m_busy = 0; m_issue = 0; m_rd = 0;
      end else if (bus_wr && bus_addr == 8'h2C && bus_wdata[0] && m_gnt && !m_busy) begin
        m_page = bus_wdata[31:24]; m_reg = bus_wdata[23:16]; m_wr = bus_wdata[1];
        m_bwd = {m_wdh, m_wdl}; m_busy = 1; m_issue = 1;
      end else if (m_issue) begin
        m_issue = 0;
      end else if (m_busy && be_rsp_valid) begin
        m_busy = 0;
        if (!m_wr) m_rd = be_rsp_data;
      end
      if (bus_wr && bus_addr == 8'h30) m_wdh = bus_wdata;
      if (bus_wr && bus_addr == 8'h34) m_wdl = bus_wdata;
      if (bus_wr && bus_addr == 8'h40) begin m_req = bus_wdata[3]; m_ien = bus_wdata[1]; end
      m_evt = (m_evt & ~((bus_wr && bus_addr == 8'h44) ? bus_wdata[12:0] : 13'h0)) | evt_pulse;
      m_gnt = n_gnt;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && cyc > 1) begin
      chk("R6 strobe", 64'(be_valid), 64'(m_issue));
      if (m_issue) begin
        chk("R6 page", 64'(be_page), 64'(m_page));
        chk("R6 reg", 64'(be_reg), 64'(m_reg));
        chk("R6 we", 64'(be_we), 64'(m_wr));
        chk("R5 wdata", be_wdata, m_bwd);
      end
      chk("R10 irq", 64'(irq), 64'(m_ien && (|m_evt)));
      chk("R11 rdata", 64'(bus_rdata), 64'(m_rdata));
    end
  end

  // back-end responder
  always @(negedge clk) begin
    be_rsp_valid <= 1'b0;
    if (rsp_pend) begin
      if (rsp_cnt <= 1) begin
        be_rsp_valid <= 1'b1;
        be_rsp_data  <= rsp_pattern(rsp_pg, rsp_rg);
        rsp_pend = 0;
      end else rsp_cnt--;
    end
    if (be_valid) begin
      rsp_pend = 1; rsp_cnt = rsp_lat; rsp_pg = be_page; rsp_rg = be_reg;
    end
  end

  task automatic hwrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic hread(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic expect_rd(logic [7:0] a, logic [31:0] exp, string req);
    logic [31:0] d;
    hread(a, d);
    chk(req, 64'(d), 64'(exp));
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 40; i++) begin
      hread(8'h2C, d);
      if (!d[0]) break;
    end
    chk("R3 busy clears", 64'(d[0]), 64'h0);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [63:0] p;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", 64'(irq), 64'h0);
    chk("R1 strobe", 64'(be_valid), 64'h0);
    expect_rd(8'h2C, 32'h0, "R1 cmd");
    expect_rd(8'h38, 32'h0, "R1 rdh");
    expect_rd(8'h40, 32'h40, "R1 ctrl");
    // R4 command without grant
    hwrite(8'h2C, 32'h1234_0001);
    idle(3);
    expect_rd(8'h2C, 32'h0, "R4 no grant");
    // R2 request blocked by fabric owner
    fabric_own = 1'b1;
    hwrite(8'h40, 32'h0000_000A);
    idle(3);
    expect_rd(8'h40, 32'h4A, "R2 blocked");
    fabric_own = 1'b0;
    idle(2);
    expect_rd(8'h40, 32'h5A, "R2 granted");
    // R5 R6 write transfer, latency 3
    hwrite(8'h30, 32'hDEAD_BEEF);
    hwrite(8'h34, 32'h0123_4567);
    expect_rd(8'h30, 32'hDEAD_BEEF, "R5 wdh");
    expect_rd(8'h34, 32'h0123_4567, "R5 wdl");
    rsp_lat = 3;
    hwrite(8'h2C, 32'h0520_0003);
    expect_rd(8'h2C, 32'h0520_0003, "R3 busy readback");
    wait_idle();
    expect_rd(8'h38, 32'h0, "R7 write keeps rdh");
    expect_rd(8'h3C, 32'h0, "R7 write keeps rdl");
    // R7 reads at latencies 1 and 8
    rsp_lat = 1;
    hwrite(8'h2C, 32'h1008_0001);
    wait_idle();
    p = rsp_pattern(8'h10, 8'h08);
    expect_rd(8'h38, p[63:32], "R7 rdh lat1");
    expect_rd(8'h3C, p[31:0], "R7 rdl lat1");
    rsp_lat = 8;
    hwrite(8'h2C, 32'hFF7E_0001);
    // R4 command while busy
    hwrite(8'h2C, 32'h3344_0001);
    expect_rd(8'h2C, 32'hFF7E_0001, "R4 busy ignore");
    wait_idle();
    p = rsp_pattern(8'hFF, 8'h7E);
    expect_rd(8'h3C, p[31:0], "R7 rdl lat8");
    // R8 abort with response pending
    rsp_lat = 6;
    hwrite(8'h2C, 32'h2211_0001);
    hwrite(8'h2C, 32'h0000_0004);
    expect_rd(8'h2C, 32'h2211_0000, "R8 busy cleared");
    idle(10);
    expect_rd(8'h38, 32'h0, "R8 rdh zero");
    expect_rd(8'h3C, 32'h0, "R8 rdl zero");
    // R9 R10 event capture
    @(negedge clk); evt_pulse = 13'h0201;
    @(negedge clk); evt_pulse = 13'h0;
    chk("R10 irq on", 64'(irq), 64'h1);
    expect_rd(8'h44, 32'h201, "R9 capture");
    hwrite(8'h44, 32'h1);
    expect_rd(8'h44, 32'h200, "R9 clear one");
    @(negedge clk); bus_addr = 8'h44; bus_wdata = 32'h200; bus_wr = 1'b1; evt_pulse = 13'h0200;
    @(negedge clk); bus_wr = 1'b0; evt_pulse = 13'h0;
    expect_rd(8'h44, 32'h200, "R9 pulse beats clear");
    hwrite(8'h40, 32'h8);
    @(negedge clk);
    chk("R10 irq disabled", 64'(irq), 64'h0);
    hwrite(8'h44, 32'h1FFF);
    expect_rd(8'h44, 32'h0, "R9 clear all");
    // R2 release
    hwrite(8'h40, 32'h0);
    idle(1);
    expect_rd(8'h40, 32'h40, "R2 release");
    // R11 unmapped
    expect_rd(8'h10, 32'h0, "R11 unmapped");
    idle(4);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule